// File: doc/BRIEF.md
# Held-Low Input Qualification Unit

This block watches a small set of raw push-button bits and answers, on demand, whether a chosen bit has stayed at logic 0 without interruption for a fixed hold window of 40 ms. Each bit passes through its own synchroniser and feeds its own saturating hold counter. The counters run on every clock whether or not anyone asks, so an answer is always ready.

A processor-side query names one input (operand 0 or operand 1) and a destination register (A or B). One cycle later the block returns a write strobe, the register select and a full 8-bit register value of 1 (qualified) or 0 (not qualified). The number of clock cycles in the window is worked out at elaboration from the clock frequency and window length parameters.

Top module: `hlq_unit`

## Requirements
- R1: `q_sel` value 0 queries `btn_raw[0]` and value 1 queries `btn_raw[1]`; the state of the other input has no effect on the answer.
- R2: With TERM = CLK_HZ*HOLD_MS/1000 cycles, the answer to a query accepted at rising edge q is 1 exactly when the selected raw bit was sampled as 0 at each of the TERM consecutive edges ending at edge q-3; otherwise it is 0.
- R3: `rsp_data` is a whole register value: 1 (bit 0 set, all upper bits 0) for qualified, all zeros otherwise.
- R4: `rsp_we` is high for exactly the one cycle following each cycle in which `q_valid` is high, and low otherwise.
- R5: `rsp_dst` returns the `q_dst` of the accepted query (0 selects register A, 1 selects register B).
- R6: While `rst` is high `rsp_we` and `rsp_data` are 0, and after reset no input reports qualified until a full window of low samples taken after reset has elapsed.
- R7: A single sampled 1 on an input restarts its window, so the next qualified answer needs TERM fresh low samples.
- R8: Hold counters advance on every cycle whether or not queries arrive, and stop at TERM while the input stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | N_IN | Raw asynchronous button bits |
| q_valid | input | 1 | One-cycle query strobe |
| q_sel | input | SEL_W | Input operand selected by the query |
| q_dst | input | 1 | Destination register of the query (0 = A, 1 = B) |
| rsp_we | output | 1 | One-cycle register write strobe |
| rsp_dst | output | 1 | Destination register of the response |
| rsp_data | output | DATA_W | Result value, 1 or 0 |

## Verification
The bench shrinks the window to eight cycles and sweeps both inputs through long low runs, single-cycle high glitches and idle stretches with no queries, predicting each answer from its own record of raw samples. The exact window edge is probed: a design with an off-by-one terminal compare or a missing synchroniser stage answers 1 one query early or late. A counter that fails to clear on a single high sample keeps reporting qualified after a glitch, and one that only advances during queries reports 0 after a long quiet low stretch. Swapped operand decode or a dropped destination bit shows up as answers that track the wrong input or land in the wrong register.

// File: rtl/hlq_pkg.sv
package hlq_pkg;

   // Cycles in the hold window for a clock rate and a window length in ms.
   function automatic int hold_cycles(input longint clk_hz, input int ms);
      return int'((clk_hz * longint'(ms)) / 1000);
   endfunction

   // Counter width able to hold the value term.
   function automatic int cnt_width(input int term);
      return (term < 1) ? 1 : $clog2(term + 1);
   endfunction

   // Width of a select field for n choices, at least one bit.
   function automatic int sel_width(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/hlq_sync.sv
module hlq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hlq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/hlq_hold_counter.sv
module hlq_hold_counter #(
   parameter int TERM = 8,
   parameter int CW   = hlq_pkg::cnt_width(TERM)
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl,        // synchronised input level, 1 = released
   output logic qualified
);

   localparam logic [CW-1:0] TERM_V = CW'(TERM);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (lvl)           cnt <= '0;
      else if (cnt != TERM_V) cnt <= cnt + 1'b1;
   end

   assign qualified = (cnt == TERM_V);

   // R8: counter never passes the terminal value
   p_saturate_r8: assert property (@(posedge clk) disable iff (rst)
      cnt <= TERM_V);

   // R7: a sampled high leaves the input unqualified on the next cycle
   p_restart_r7: assert property (@(posedge clk) disable iff (rst)
      lvl |=> !qualified);

   // R2: qualification only appears after a low sample
   p_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(qualified) |-> !$past(lvl));

   // R8: once qualified, it stays qualified while the level stays low
   p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (qualified && !lvl) |=> qualified);

endmodule

// File: rtl/hlq_unit.sv
module hlq_unit #(
   parameter int  CLK_HZ      = 50_000_000,
   parameter int  HOLD_MS     = 40,
   parameter int  N_IN        = 2,
   parameter int  DATA_W      = 8,
   parameter int  SYNC_STAGES = 2,
   localparam int SEL_W       = hlq_pkg::sel_width(N_IN)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_IN-1:0]   btn_raw,
   input  logic              q_valid,
   input  logic [SEL_W-1:0]  q_sel,
   input  logic              q_dst,
   output logic              rsp_we,
   output logic              rsp_dst,
   output logic [DATA_W-1:0] rsp_data
);

   localparam int TERM = hlq_pkg::hold_cycles(longint'(CLK_HZ), HOLD_MS);
   localparam int CW   = hlq_pkg::cnt_width(TERM);

   generate
      if (TERM < 1) begin : g_bad_term
         $error("hlq_unit: hold window must be at least one cycle");
      end
      if (N_IN < 1) begin : g_bad_inputs
         $error("hlq_unit: N_IN must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("hlq_unit: DATA_W must be at least 2");
      end
   endgenerate

   logic [N_IN-1:0] lvl_s;
   logic [N_IN-1:0] qual;
   logic            hit;

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_chan
         hlq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
         ) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (btn_raw[i]),
            .dout (lvl_s[i])
         );

         hlq_hold_counter #(
            .TERM (TERM),
            .CW   (CW)
         ) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .lvl       (lvl_s[i]),
            .qualified (qual[i])
         );
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
         if (int'(q_sel) == i) hit = qual[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_we   <= 1'b0;
         rsp_dst  <= 1'b0;
         rsp_data <= '0;
      end else begin
         rsp_we   <= q_valid;
         rsp_dst  <= q_valid ? q_dst : rsp_dst;
         rsp_data <= q_valid ? DATA_W'(hit) : '0;
      end
   end

   // R4: every query is answered on the next cycle
   p_answer_r4: assert property (@(posedge clk) disable iff (rst)
      q_valid |=> rsp_we);

   // R4: no write strobe without a query
   p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      !q_valid |=> !rsp_we);

   // R5: destination travels with the query
   p_dst_r5: assert property (@(posedge clk) disable iff (rst)
      q_valid |=> rsp_dst == $past(q_dst));

   // R3: result is a whole value of 1 or 0
   p_value_r3: assert property (@(posedge clk) disable iff (rst)
      rsp_data[DATA_W-1:1] == '0);

   // R6: reset leaves the response idle
   p_reset_r6: assert property (@(posedge clk)
      $past(rst) |-> (!rsp_we && rsp_data == '0));

endmodule

// File: tb/hlq_unit_test.sv
module hlq_unit_test;

   localparam int CLK_HZ  = 200;
   localparam int HOLD_MS = 40;
   localparam int TERM    = CLK_HZ * HOLD_MS / 1000;   // 8 cycles
   localparam int MAXE    = 8192;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] btn_raw = 2'b11;
   logic       q_valid = 1'b0;
   logic [0:0] q_sel = 1'b0;
   logic       q_dst = 1'b0;
   logic       rsp_we;
   logic       rsp_dst;
   logic [7:0] rsp_data;

   int n_chk = 0;
   int n_bad = 0;
   int e = 0;                 // index of the next post-reset edge
   int run_hist [2][MAXE];    // consecutive low samples ending at each edge
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;      // 100 MHz

   hlq_unit #(
      .CLK_HZ  (CLK_HZ),
      .HOLD_MS (HOLD_MS),
      .N_IN    (2),
      .DATA_W  (8)
   ) uut (
      .clk      (clk),
      .rst      (rst),
      .btn_raw  (btn_raw),
      .q_valid  (q_valid),
      .q_sel    (q_sel),
      .q_dst    (q_dst),
      .rsp_we   (rsp_we),
      .rsp_dst  (rsp_dst),
      .rsp_data (rsp_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, e, act, exp);
      end
   endtask

   function automatic int expect_hit(input int ch, input int q);
      int idx = q - 3;
      if (idx < 0) return 0;
      return (run_hist[ch][idx] >= TERM) ? 1 : 0;
   endfunction

   // Drive inputs, take one edge, record samples, check the response.
   task automatic step(input logic [1:0] raw, input logic qv,
                       input logic sel, input logic dst, input string tag);
      btn_raw = raw;
      q_valid = qv;
      q_sel   = sel;
      q_dst   = dst;
      @(posedge clk);
      for (int c = 0; c < 2; c++) begin
         if (raw[c]) run_hist[c][e] = 0;
         else        run_hist[c][e] = (e == 0) ? 1 : run_hist[c][e-1] + 1;
      end
      #1;
      check({tag, " R4 strobe"}, int'(rsp_we), int'(qv));
      if (qv) begin
         check({tag, " R5 dst"}, int'(rsp_dst), int'(dst));
         check({tag, " R2 R3 value"}, int'(rsp_data), expect_hit(int'(sel), e));
      end
      e++;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R6: reset state, with queries and low inputs held during reset
      btn_raw = 2'b00;
      q_valid = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      check("R6 reset strobe", int'(rsp_we), 0);
      check("R6 reset data", int'(rsp_data), 0);
      @(negedge clk);
      rst = 1'b0;

      // R6 R2: both low from release, query every cycle across the window edge
      for (int k = 0; k < 16; k++)
         step(2'b00, 1'b1, k[0], k[1], "R6 window after reset");

      // R1: input 1 released while input 0 stays low
      for (int k = 0; k < 12; k++)
         step(2'b10, 1'b1, k[0], ~k[0], "R1 independent inputs");

      // R7: single-cycle glitch on input 0, then low again
      step(2'b01, 1'b1, 1'b0, 1'b0, "R7 glitch");
      for (int k = 0; k < 14; k++)
         step(2'b00, 1'b1, 1'b0, k[0], "R7 restart");

      // R8: long quiet low stretch with no queries, then ask
      step(2'b11, 1'b0, 1'b0, 1'b0, "R8 release");
      for (int k = 0; k < 30; k++)
         step(2'b00, 1'b0, 1'b0, 1'b0, "R8 idle");
      step(2'b00, 1'b1, 1'b0, 1'b1, "R8 after idle ch0");
      step(2'b00, 1'b1, 1'b1, 1'b0, "R8 after idle ch1");

      // Sweep: sparse high glitches, random queries
      for (int k = 0; k < 3000; k++) begin
         logic [1:0] r;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r[0] = (lfsr[3:0] == 4'h0);
         r[1] = (lfsr[7:4] == 4'h0) || (k % 97 == 5);
         step(r, lfsr[8], lfsr[9], lfsr[10], "sweep");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule